// File: doc/BRIEF.md
# Conditional Branch and Return-Stack Unit

This block owns the 13-bit program counter of a small 8-bit accumulator processor and handles its control-transfer instructions: jumps, calls and returns. Each kind exists in a conditional form and an unconditional form. A step strobe presents one opcode byte and the two bytes that follow it. The unit decodes the opcode and, for a conditional form, tests one of four processor flags against a required sense. It then either loads a new program counter or steps past the instruction.

Calls save a return address on a small internal hardware stack and returns restore it. A push into a full stack or a pop from an empty stack does not disturb the stack. Such an attempt sets a sticky error flag, and the unit treats the instruction as not taken. For opcodes that do not transfer control, the unit advances the program counter by the length of the instruction, so an instruction fetcher can follow the counter directly.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset the program counter is 0, the taken output is 0, the stack-error flag is 0 and the return stack is empty.
- R2: On a step with an opcode that is not a transfer, the counter advances by the instruction length, wrapping modulo 2^13, and taken goes to 0. The length is 3 for pattern 01xxxxx0, 2 for 00xxx100 and 00xxx110, and 1 for every other opcode.
- R3: Without a step strobe, the program counter, taken, the stack and the error flag all hold.
- R4: Opcode bits 5:3 form the condition field. Bit 5 is the required sense (1 means the flag must be 1). Bits 4:3 select the flag: 00 carry, 01 zero, 10 sign, 11 parity-even. The parity-even input is 1 for even parity. The condition holds when the selected flag equals the sense.
- R5: A conditional jump (01ccc000) whose condition holds, or the unconditional jump 0x44, loads the counter with the 13-bit target and sets taken to 1.
- R6: A conditional call (01ccc010) whose condition holds, or the unconditional call 0x46, pushes the current counter plus 3 and then loads the target. Taken goes to 1.
- R7: A conditional return (00ccc011) whose condition holds, or the unconditional return 0x07, pops the top of the stack into the counter. Taken goes to 1.
- R8: When a condition fails, a jump or call advances the counter by 3 and a return advances it by 1. Taken goes to 0 and the stack is left unchanged.
- R9: The stack holds 8 entries in last-in first-out order, so nested returns restore the addresses in reverse order of the calls.
- R10: A call that would be taken while the stack is full sets the error flag and leaves the stack unchanged. The counter advances by 3 and taken is 0.
- R11: A return that would be taken while the stack is empty sets the error flag. The counter advances by 1 and taken is 0.
- R12: Once set, the error flag stays set until reset.
- R13: The target is built from the low operand byte and bits 4:0 of the high operand byte. Bits 7:5 of the high byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stepEn | input | 1 | Execute the presented instruction this cycle |
| opByte | input | 8 | Opcode byte |
| addrLo | input | 8 | First operand byte (target low) |
| addrHi | input | 8 | Second operand byte (target high) |
| flagCarry | input | 1 | Carry flag |
| flagZero | input | 1 | Zero flag |
| flagSign | input | 1 | Sign flag |
| flagParEven | input | 1 | 1 when parity is even |
| pcOut | output | 13 | Program counter |
| taken | output | 1 | Last stepped instruction transferred control |
| stackErr | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A single step can both evaluate a condition and hit a stack limit, so the two must be resolved together. The bench fills the stack with eight calls and then issues a conditional call whose condition is false. It expects the counter to advance by 3 with no error. Next it issues an unconditional call and expects the error flag, an advance of 3 and taken low. Eight returns then prove that neither call changed the stored addresses. A matching case, a false conditional return on an empty stack followed by a true one, checks that the error is raised only when the pop would really happen.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef struct packed {
    logic       loadTgt;
    logic       loadRet;
    logic       doPush;
    logic       doPop;
    logic [1:0] advLen;
    logic       raiseErr;
    logic       isTaken;
  } flowStrobe_t;

  typedef enum logic [1:0] {
    FLAG_CARRY  = 2'b00,
    FLAG_ZERO   = 2'b01,
    FLAG_SIGN   = 2'b10,
    FLAG_PARITY = 2'b11
  } flagSel_t;

  localparam logic [7:0] OP_JMP_ALWAYS  = 8'h44;
  localparam logic [7:0] OP_CALL_ALWAYS = 8'h46;
  localparam logic [7:0] OP_RET_ALWAYS  = 8'h07;
endpackage

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
(
  input  logic [2:0] condField,
  input  logic       flagCarry,
  input  logic       flagZero,
  input  logic       flagSign,
  input  logic       flagParEven,
  output logic       condTrue
);
  flagSel_t flagSel;
  logic     selFlag;

  always_comb begin
    flagSel = flagSel_t'(condField[1:0]);
    unique case (flagSel)
      FLAG_CARRY:  selFlag = flagCarry;
      FLAG_ZERO:   selFlag = flagZero;
      FLAG_SIGN:   selFlag = flagSign;
      FLAG_PARITY: selFlag = flagParEven;
      default:     selFlag = 1'b0;
    endcase
    // R4: sense bit must match the chosen flag
    condTrue = (selFlag == condField[2]);
  end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepEn,
  input  logic [7:0]  opByte,
  input  logic        condTrue,
  input  logic        stackFull,
  input  logic        stackEmpty,
  output flowStrobe_t strobe
);
  logic isJmpCond, isCallCond, isRetCond;
  logic wantJmp, wantCall, wantRet;
  logic [1:0] instLen;

  always_comb begin
    isJmpCond  = (opByte[7:6] == 2'b01) && (opByte[2:0] == 3'b000);
    isCallCond = (opByte[7:6] == 2'b01) && (opByte[2:0] == 3'b010);
    isRetCond  = (opByte[7:6] == 2'b00) && (opByte[2:0] == 3'b011);

    // R2: instruction length by opcode class
    if (opByte[7:6] == 2'b01 && !opByte[0])
      instLen = 2'd3;
    else if (opByte[7:6] == 2'b00 && opByte[2] && !opByte[0])
      instLen = 2'd2;
    else
      instLen = 2'd1;

    wantJmp  = (opByte == OP_JMP_ALWAYS)  || (isJmpCond  && condTrue);
    wantCall = (opByte == OP_CALL_ALWAYS) || (isCallCond && condTrue);
    wantRet  = (opByte == OP_RET_ALWAYS)  || (isRetCond  && condTrue);

    strobe.doPush   = wantCall && !stackFull;
    strobe.doPop    = wantRet && !stackEmpty;
    strobe.loadTgt  = wantJmp || strobe.doPush;
    strobe.loadRet  = strobe.doPop;
    strobe.raiseErr = (wantCall && stackFull) || (wantRet && stackEmpty);
    strobe.isTaken  = strobe.loadTgt || strobe.loadRet;
    strobe.advLen   = instLen;
  end

  // R7: a step never both pushes and pops
  p_push_pop_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |-> !(strobe.doPush && strobe.doPop));

  // R11: a stack fault is never reported as a taken transfer
  p_fault_not_taken_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && strobe.raiseErr) |-> !strobe.isTaken);
endmodule

// File: rtl/flow_datapath.sv
module flow_datapath
  import flow_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepEn,
  input  flowStrobe_t     strobe,
  input  logic [PC_W-1:0] targetAddr,
  output logic [PC_W-1:0] pcOut,
  output logic            taken,
  output logic            stackErr,
  output logic            stackFull,
  output logic            stackEmpty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PC_W-1:0]  CALL_LEN = PC_W'(3);

  logic [PC_W-1:0]  pcReg;
  logic [PC_W-1:0]  stackMem [DEPTH];
  logic [CNT_W-1:0] stackCnt;
  logic [IDX_W-1:0] pushIdx, topIdx;
  logic [PC_W-1:0]  pcSeq, pcNext;

  always_comb begin
    stackFull  = (stackCnt == FULL_CNT);
    stackEmpty = (stackCnt == '0);
    pushIdx    = IDX_W'(stackCnt);
    topIdx     = IDX_W'(stackCnt - 1'b1);
    pcSeq      = pcReg + PC_W'(strobe.advLen);
    if (strobe.loadTgt)      pcNext = targetAddr;
    else if (strobe.loadRet) pcNext = stackMem[topIdx];
    else                     pcNext = pcSeq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= '0;
      taken    <= 1'b0;
      stackErr <= 1'b0;
      stackCnt <= '0;
    end else if (stepEn) begin
      pcReg <= pcNext;
      taken <= strobe.isTaken;
      if (strobe.raiseErr) stackErr <= 1'b1;
      if (strobe.doPush)     stackCnt <= stackCnt + 1'b1;
      else if (strobe.doPop) stackCnt <= stackCnt - 1'b1;
    end
  end

  // return address: the instruction after the three-byte call
  always_ff @(posedge clk) begin
    if (stepEn && strobe.doPush) stackMem[pushIdx] <= pcReg + CALL_LEN;
  end

  assign pcOut = pcReg;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> ($stable(pcOut) && $stable(taken) && $stable(stackCnt) && $stable(stackErr)));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackCnt <= FULL_CNT);

  p_fault_keeps_stack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && strobe.raiseErr) |=> ($stable(stackCnt) && stackErr));

  p_push_grows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && strobe.doPush) |=> (stackCnt == $past(stackCnt) + 1'b1));

  p_target_loaded_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && strobe.loadTgt) |=> (taken && pcOut == $past(targetAddr)));
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import flow_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepEn,
  input  logic [7:0]      opByte,
  input  logic [7:0]      addrLo,
  input  logic [7:0]      addrHi,
  input  logic            flagCarry,
  input  logic            flagZero,
  input  logic            flagSign,
  input  logic            flagParEven,
  output logic [PC_W-1:0] pcOut,
  output logic            taken,
  output logic            stackErr
);
  flowStrobe_t     strobe;
  logic            condTrue, stackFull, stackEmpty;
  logic [PC_W-1:0] targetAddr;

  // R13: only the low PC_W-8 bits of the high byte reach the target
  assign targetAddr = PC_W'({addrHi, addrLo});

  flow_cond uCond (
    .condField(opByte[5:3]), .flagCarry(flagCarry), .flagZero(flagZero),
    .flagSign(flagSign), .flagParEven(flagParEven), .condTrue(condTrue)
  );

  flow_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .opByte(opByte), .condTrue(condTrue),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .strobe(strobe)
  );

  flow_datapath #(.PC_W(PC_W), .DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .strobe(strobe), .targetAddr(targetAddr),
    .pcOut(pcOut), .taken(taken), .stackErr(stackErr),
    .stackFull(stackFull), .stackEmpty(stackEmpty)
  );
endmodule

// File: tb/tb_flow_ctl_unit.sv
module tb_flow_ctl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [7:0]  opByte = 8'h00, addrLo = 8'h00, addrHi = 8'h00;
  logic        flagCarry = 1'b0, flagZero = 1'b0, flagSign = 1'b0, flagParEven = 1'b0;
  logic [12:0] pcOut;
  logic        taken, stackErr;
  int          errCnt = 0, chkCnt = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flow_ctl_unit dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .opByte(opByte), .addrLo(addrLo),
    .addrHi(addrHi), .flagCarry(flagCarry), .flagZero(flagZero), .flagSign(flagSign),
    .flagParEven(flagParEven), .pcOut(pcOut), .taken(taken), .stackErr(stackErr)
  );

  // {op, lo, hi, flags{C,Z,S,Peven}, expected pc, expected taken}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {8'h80, 8'h00, 8'h00, 4'b0000, 13'h0001, 1'b0},  // R2 one byte
    {8'h04, 8'h00, 8'h00, 4'b0000, 13'h0003, 1'b0},  // R2 two bytes
    {8'h06, 8'h00, 8'h00, 4'b0000, 13'h0005, 1'b0},  // R2 two bytes
    {8'h41, 8'h00, 8'h00, 4'b0000, 13'h0006, 1'b0},  // R2 one byte
    {8'h40, 8'h34, 8'h12, 4'b0000, 13'h1234, 1'b1},  // R4 R5 carry false
    {8'h40, 8'h34, 8'h12, 4'b1000, 13'h1237, 1'b0},  // R8 carry set
    {8'h68, 8'h00, 8'hE5, 4'b0100, 13'h0500, 1'b1},  // R13 zero true
    {8'h70, 8'h00, 8'h00, 4'b0000, 13'h0503, 1'b0},  // R8 sign true fails
    {8'h78, 8'hFF, 8'h1F, 4'b0001, 13'h1FFF, 1'b1},  // R4 parity even
    {8'h80, 8'h00, 8'h00, 4'b0000, 13'h0000, 1'b0},  // R2 wrap
    {8'h58, 8'h00, 8'h00, 4'b0001, 13'h0003, 1'b0},  // R8 parity-odd test fails
    {8'h44, 8'h10, 8'h00, 4'b1111, 13'h0010, 1'b1},  // R5 unconditional
    {8'h50, 8'h20, 8'h01, 4'b1101, 13'h0120, 1'b1},  // R4 sign false
    {8'h48, 8'h00, 8'h00, 4'b0100, 13'h0123, 1'b0}   // R8 zero false fails
  };

  task automatic check(input string req, input logic [12:0] expPc, input logic expTk,
                       input logic expErr);
    chkCnt++;
    if (pcOut !== expPc || taken !== expTk || stackErr !== expErr) begin
      errCnt++;
      $display("FAIL %s: pc=%h taken=%b err=%b expected pc=%h taken=%b err=%b",
               req, pcOut, taken, stackErr, expPc, expTk, expErr);
    end
  endtask

  task automatic step(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [3:0] fl);
    @(negedge clk);
    opByte = op; addrLo = lo; addrHi = hi;
    {flagCarry, flagZero, flagSign, flagParEven} = fl;
    stepEn = 1'b1;
    @(negedge clk);
    stepEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", 13'h0000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][41:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:14]);
      check($sformatf("R2 R4 R5 R8 R13 vector %0d", i), VEC[i][13:1], VEC[i][0], 1'b0);
    end

    // R3: jump presented without a strobe
    @(negedge clk);
    opByte = 8'h44; addrLo = 8'h55; addrHi = 8'h05;
    repeat (2) @(negedge clk);
    check("R3 hold", 13'h0123, 1'b0, 1'b0);

    // R6 R7 R9: nested calls and returns
    doReset();
    step(8'h46, 8'h00, 8'h01, 4'b0000);
    check("R6 call always", 13'h0100, 1'b1, 1'b0);
    step(8'h62, 8'h00, 8'h02, 4'b1000);
    check("R6 call carry true", 13'h0200, 1'b1, 1'b0);
    step(8'h2B, 8'h00, 8'h00, 4'b0100);
    check("R7 return zero true", 13'h0103, 1'b1, 1'b0);
    step(8'h07, 8'h00, 8'h00, 4'b0000);
    check("R9 second return", 13'h0003, 1'b1, 1'b0);
    step(8'h2B, 8'h00, 8'h00, 4'b0000);
    check("R8 return not taken", 13'h0004, 1'b0, 1'b0);
    step(8'h62, 8'h00, 8'h07, 4'b0000);
    check("R8 call not taken", 13'h0007, 1'b0, 1'b0);
    step(8'h07, 8'h00, 8'h00, 4'b0000);
    check("R11 underflow", 13'h0008, 1'b0, 1'b1);
    step(8'h44, 8'h00, 8'h03, 4'b0000);
    check("R12 error sticky", 13'h0300, 1'b1, 1'b1);
    doReset();
    check("R1 reset clears error", 13'h0000, 1'b0, 1'b0);

    // R10: fill the stack, then a false and a true call at the limit
    for (int k = 0; k < 8; k++) begin
      step(8'h46, 8'h00, 8'(k + 1), 4'b0000);
      check("R9 fill call", 13'((k + 1) * 256), 1'b1, 1'b0);
    end
    step(8'h62, 8'h00, 8'h10, 4'b0000);
    check("R10 false call on full stack", 13'h0803, 1'b0, 1'b0);
    step(8'h46, 8'h00, 8'h10, 4'b0000);
    check("R10 overflow", 13'h0806, 1'b0, 1'b1);
    for (int k = 7; k >= 0; k--) begin
      step(8'h07, 8'h00, 8'h00, 4'b0000);
      check("R9 R10 unwind", 13'(k * 256 + 3), 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule